// File: doc/BRIEF.md
# Link-Layer Receive Error Statistics Counters

This block keeps two 16-bit statistics counters for a link-layer receiver. The first counts malformed link-control packets, which are those with a bad CRC or a bad length. The second counts negative-acknowledge packets that arrive. Packet parsing happens upstream. The block receives one single-cycle strobe per detected event on a separate input for each counter.

Software reads each counter through a simple register bus. The bus carries a one-cycle read or write strobe and a word address. Each counter appears in the low 16 bits of its own 32-bit read-only register, and the two registers sit at adjacent word addresses. A read returns the count and clears the counter in the same step, so each read gives the number of events since the previous read.

The counters saturate instead of wrapping. An event that lands in the same cycle as a read of its counter is kept: the counter restarts at one.

Top module: `linkstat_counters`

## Requirements
- R1: After reset both counts are zero, `bus_rvalid` is low and `bus_rdata` is zero.
- R2: Register layout. The malformed-control count is at word address `BASE_WORD`. The negative-acknowledge count is at `BASE_WORD+1`. The count occupies bits 15:0 of the read word. Bits 31:16 always read zero. A read of any other word address returns zero.
- R3: A read is a cycle with `bus_rd` high and `bus_wr` low. Its data is registered. `bus_rvalid` is high in the cycle after each read and low otherwise, and `bus_rdata` holds the read word in that cycle.
- R4: Each cycle with a counter's event strobe high and no read of that counter raises that count by exactly one, until the count reaches 16'hFFFF.
- R5: A count at 16'hFFFF stays at 16'hFFFF on further events and never wraps.
- R6: A read returns the count as it stood before the read and clears that counter to zero.
- R7: When an event and a read of the same counter fall in the same cycle, the read returns the old count and the counter becomes one. This also holds when the old count is 16'hFFFF.
- R8: A cycle with `bus_wr` high never changes a count, never clears it and produces no read data, even if `bus_rd` is also high.
- R9: The two counters are independent. A read of one counter and the events of one counter leave the other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_bad_ctl | input | 1 | One-cycle strobe for each malformed link-control packet |
| evt_nak | input | 1 | One-cycle strobe for each negative-acknowledge packet received |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (writes are ignored) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data (unused) |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High in the cycle after a read |

## Verification
The assertions assume the following about the inputs:

- The event strobes and bus strobes are synchronous to `clk`.
- No stimulus is applied while the internal synchronized reset is still low.
- An event may coincide with any bus access.

The stimulus meets these assumptions in three ways:

- It drives every input at the falling edge.
- It waits several cycles after releasing reset.
- It mixes random events, reads, writes and combined read-write cycles with directed runs that drive the negative-acknowledge counter well past saturation and then read it with an event in the same cycle.

// File: rtl/linkstat_pkg.sv
package linkstat_pkg;
  // Number of statistics counters held by the block.
  localparam int NUM_CNT = 2;
  // Width of a bus register word.
  localparam int REG_W   = 32;

  // Index of each counter; also its word offset from the base address.
  typedef enum int {
    IDX_BAD_CTL = 0,
    IDX_NAK     = 1
  } cnt_idx_e;

  // Next value of a saturating clear-on-read counter.
  function automatic logic [63:0] sat_next(input logic [63:0] cur,
                                           input logic [63:0] max_val,
                                           input logic evt,
                                           input logic clr);
    logic [63:0] r;
    if (clr)
      r = evt ? 64'd1 : 64'd0;
    else if (evt && (cur != max_val))
      r = cur + 64'd1;
    else
      r = cur;
    return r;
  endfunction
endpackage

// File: rtl/linkstat_rst_sync.sv
module linkstat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sync_q <= '0;
    else
      sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/linkstat_sat_cnt.sv
module linkstat_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_max;
  logic             cnt_en;

  always_comb begin
    at_max = &cnt_q;
    cnt_en = clr | (evt & ~at_max);
    if (clr)
      cnt_d = evt ? CNT_W'(1) : '0;
    else
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/linkstat_rd_decode.sv
module linkstat_rd_decode #(
  parameter int ADDR_W    = 10,
  parameter int BASE_WORD = 0,
  parameter int NUM_CNT   = 2
) (
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               rd_ok,
  output logic [NUM_CNT-1:0] rd_hit
);
  // A write, alone or together with a read strobe, never reads.
  assign rd_ok = bus_rd & ~bus_wr;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(BASE_WORD + g);
    assign rd_hit[g] = rd_ok && (bus_addr == WORD_ADDR);
  end
endmodule

// File: rtl/linkstat_rd_port.sv
module linkstat_rd_port #(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 16,
  parameter int REG_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_ok,
  input  logic [NUM_CNT-1:0]       rd_hit,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic [REG_W-1:0]         rdata,
  output logic                     rvalid
);
  logic [REG_W-1:0] word_d;
  logic [REG_W-1:0] rdata_q;
  logic             rvalid_q;

  always_comb begin
    word_d = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_hit[i])
        word_d[CNT_W-1:0] = cnt_flat[i*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (rd_ok)
      rdata_q <= word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rvalid_q <= 1'b0;
    else
      rvalid_q <= rd_ok;
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/linkstat_counters.sv
module linkstat_counters #(
  parameter int ADDR_W    = 10,
  parameter int BASE_WORD = 0,
  parameter int CNT_W     = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           evt_bad_ctl,
  input  logic                           evt_nak,
  input  logic                           bus_rd,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [linkstat_pkg::REG_W-1:0] bus_wdata,
  output logic [linkstat_pkg::REG_W-1:0] bus_rdata,
  output logic                           bus_rvalid
);
  import linkstat_pkg::*;

  logic                     rst_sync_n;
  logic                     rd_ok;
  logic [NUM_CNT-1:0]       rd_hit;
  logic [NUM_CNT-1:0]       evt_vec;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic                     wdata_unused;

  // Write data has no destination; reduce it so every input is consumed.
  assign wdata_unused = ^bus_wdata;

  always_comb begin
    evt_vec              = '0;
    evt_vec[IDX_BAD_CTL] = evt_bad_ctl;
    evt_vec[IDX_NAK]     = evt_nak;
  end

  linkstat_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  linkstat_rd_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_WORD (BASE_WORD),
    .NUM_CNT   (NUM_CNT)
  ) u_decode (
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .rd_ok    (rd_ok),
    .rd_hit   (rd_hit)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    linkstat_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .evt   (evt_vec[g]),
      .clr   (rd_hit[g]),
      .cnt   (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  linkstat_rd_port #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .REG_W   (REG_W)
  ) u_rd_port (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_ok    (rd_ok),
    .rd_hit   (rd_hit),
    .cnt_flat (cnt_flat),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );
endmodule

// File: rtl/linkstat_counters_chk.sv
module linkstat_counters_chk #(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 16,
  parameter int REG_W   = 32
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic                     bus_rd,
  input logic                     bus_wr,
  input logic [NUM_CNT-1:0]       rd_hit,
  input logic [NUM_CNT-1:0]       evt_vec,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [REG_W-1:0]         bus_rdata,
  input logic                     bus_rvalid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[REG_W-1:CNT_W] == '0);

  // R3
  rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && !bus_wr) |=> bus_rvalid);

  // R8
  write_no_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_wr |=> !bus_rvalid);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    // R4
    incr_by_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (evt_vec[g] && !rd_hit[g] && cnt_flat[g*CNT_W +: CNT_W] != CNT_MAX)
      |=> cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]) + CNT_W'(1));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!rd_hit[g] && cnt_flat[g*CNT_W +: CNT_W] == CNT_MAX)
      |=> cnt_flat[g*CNT_W +: CNT_W] == CNT_MAX);

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rd_hit[g] && !evt_vec[g]) |=> cnt_flat[g*CNT_W +: CNT_W] == '0);

    // R7
    read_evt_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rd_hit[g] && evt_vec[g]) |=> cnt_flat[g*CNT_W +: CNT_W] == CNT_W'(1));

    // R6
    read_value_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      rd_hit[g] |=> bus_rdata[CNT_W-1:0] == $past(cnt_flat[g*CNT_W +: CNT_W]));

    // R8 R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!rd_hit[g] && !evt_vec[g]) |=> $stable(cnt_flat[g*CNT_W +: CNT_W]));
  end
endmodule

bind linkstat_counters linkstat_counters_chk #(
  .NUM_CNT (linkstat_pkg::NUM_CNT),
  .CNT_W   (CNT_W),
  .REG_W   (linkstat_pkg::REG_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .rd_hit     (rd_hit),
  .evt_vec    (evt_vec),
  .cnt_flat   (cnt_flat),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid)
);

// File: tb/linkstat_counters_tb.sv
`timescale 1ns/1ps
module linkstat_counters_tb;
  localparam int ADDR_W   = 10;
  localparam int BASE     = 0;
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_NAK = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(BASE + 7);
  localparam int MAX_CYC  = 200000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              evt_bad_ctl = 1'b0;
  logic              evt_nak = 1'b0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  logic [15:0] exp_ctl = '0;
  logic [15:0] exp_nak = '0;
  bit          pend = 1'b0;
  logic [15:0] pexp = '0;
  string       ptag = "";

  always #4 clk = ~clk;

  linkstat_counters #(.ADDR_W(ADDR_W), .BASE_WORD(BASE), .CNT_W(16)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_bad_ctl (evt_bad_ctl),
    .evt_nak     (evt_nak),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid)
  );

  function automatic logic [15:0] model_next(logic [15:0] cur, logic evt, logic clr);
    if (clr) return evt ? 16'd1 : 16'd0;
    if (evt && cur != 16'hFFFF) return cur + 16'd1;
    return cur;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  // One bus cycle: check the result of the previous cycle, then drive the next.
  task automatic step(input logic e_ctl, input logic e_nak, input logic rd,
                      input logic wr, input logic [ADDR_W-1:0] a, input string tag);
    bit rd_now;
    @(negedge clk);
    chk(bus_rvalid === pend, "R3", {31'd0, bus_rvalid}, {31'd0, pend});
    if (pend) begin
      chk(bus_rdata[15:0] === pexp, ptag, {16'd0, bus_rdata[15:0]}, {16'd0, pexp});
      chk(bus_rdata[31:16] === 16'd0, "R2", bus_rdata, {16'd0, pexp});
    end
    evt_bad_ctl = e_ctl;
    evt_nak     = e_nak;
    bus_rd      = rd;
    bus_wr      = wr;
    bus_addr    = a;
    bus_wdata   = $urandom;
    rd_now = rd && !wr;
    pend   = rd_now;
    ptag   = tag;
    if (rd_now)
      pexp = (a == A_CTL) ? exp_ctl : (a == A_NAK) ? exp_nak : 16'd0;
    exp_ctl = model_next(exp_ctl, e_ctl, rd_now && a == A_CTL);
    exp_nak = model_next(exp_nak, e_nak, rd_now && a == A_NAK);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, '0, "R3");
  endtask

  initial begin : watchdog
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", MAX_CYC, MAX_CYC);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    process::self().srandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    // R1: outputs held at reset values
    chk(bus_rvalid === 1'b0, "R1", {31'd0, bus_rvalid}, 32'd0);
    chk(bus_rdata === 32'd0, "R1", bus_rdata, 32'd0);
    rst_n = 1'b1;
    idle(5);

    // R1: both counts zero after reset
    step(0, 0, 1, 0, A_CTL, "R1");
    step(0, 0, 1, 0, A_NAK, "R1");
    idle(1);

    // R4 / R9: five malformed-control events, NAK counter untouched
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, '0, "R4");
    step(0, 0, 1, 0, A_NAK, "R9");
    step(0, 0, 1, 0, A_CTL, "R4");
    step(0, 0, 1, 0, A_CTL, "R6");

    // R7: event coincident with read
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, '0, "R4");
    step(1, 0, 1, 0, A_CTL, "R7");
    step(0, 0, 1, 0, A_CTL, "R7");
    // R9: a NAK read with a control event leaves the control count alone
    step(1, 0, 1, 0, A_NAK, "R9");
    step(0, 0, 1, 0, A_CTL, "R9");

    // R8: writes have no effect, also with the read strobe high
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, '0, "R4");
    step(0, 0, 0, 1, A_CTL, "R8");
    step(0, 0, 1, 1, A_CTL, "R8");
    step(0, 0, 1, 0, A_CTL, "R8");

    // R2: unmapped word reads zero
    step(1, 1, 1, 0, A_OFF, "R2");
    step(0, 0, 1, 0, A_OFF, "R2");
    step(0, 0, 1, 0, A_CTL, "R2");
    step(0, 0, 1, 0, A_NAK, "R2");

    // R5: drive the NAK counter past its maximum
    for (int i = 0; i < 65540; i++) step(0, 1, 0, 0, '0, "R5");
    step(0, 0, 1, 0, A_NAK, "R5");
    for (int i = 0; i < 65536; i++) step(0, 1, 0, 0, '0, "R5");
    // R7: saturated value read with a coincident event
    step(0, 1, 1, 0, A_NAK, "R7");
    step(0, 0, 1, 0, A_NAK, "R7");

    // R6: random mix of events, reads, writes and unmapped accesses
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? A_CTL : (sel < 8) ? A_NAK : A_OFF;
      step(logic'($urandom_range(0, 2) == 0), logic'($urandom_range(0, 2) == 0),
           logic'($urandom_range(0, 3) == 0), logic'($urandom_range(0, 7) == 0),
           a, "R6");
    end
    step(0, 0, 1, 0, A_CTL, "R6");
    step(0, 0, 1, 0, A_NAK, "R6");
    idle(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule